// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Coherence Controller

This block tracks the coherence state of every line in a small direct-mapped private cache that sits on a shared snooping bus. Each line holds a tag and one of four states: invalid, exclusive-clean, shared-clean or modified. Processor reads and writes are resolved against the tag and state array. A miss, or a write to a shared copy, goes out as a bus request and waits for a grant. When the grant arrives, the controller samples a shared-sense input from the peer caches to choose the fill state.

Alongside the processor path, the controller watches transactions that other caches place on the bus. When a snooped address matches a valid line, it reports the match on a shared-sense output in the same cycle. It offers to source the data even if its copy is clean. It then demotes the line to shared on a read, or drops it to invalid on a write or invalidate. A modified line that must be replaced is first written back through a held request/acknowledge pair. Arbitration, the data array and memory live outside the block.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset every line is invalid, and busReqValid, wbReq and cpuDone are low, so the first processor read of any address is a miss.
- R2: A read miss whose grant arrives with busSharedIn low fills the line exclusive-clean; cpuDone pulses for one cycle, the cycle after the grant, with cpuState = 1 (encoding: 0 invalid, 1 exclusive-clean, 2 shared, 3 modified).
- R3: A read miss whose grant arrives with busSharedIn high fills the line shared (cpuState = 2).
- R4: A read hit on an exclusive-clean, shared or modified line raises no bus request and no write-back, leaves the state unchanged and completes with cpuDone the cycle after cpuReq.
- R5: A write hit on an exclusive-clean line becomes modified with no bus request and completes the cycle after cpuReq.
- R6: A write hit on a shared line issues a bus request of kind 2 (invalidate) and completes as modified after the grant.
- R7: A write miss issues a bus request of kind 1 (write miss) and fills modified. A read miss uses kind 0.
- R8: A snooped transaction (snoopWrite 0 = read miss, 1 = write miss/invalidate) that matches a valid line raises snoopShared in the same cycle. supplyData is raised as well for a snooped read, whatever the line's valid state. A non-matching address raises neither.
- R9: A snooped read that matches a modified or exclusive-clean line leaves it shared.
- R10: A snooped write miss or invalidate that matches a valid line leaves it invalid.
- R11: A miss whose victim line is modified raises wbReq with the victim's address, holds it until wbAck and only then issues the bus request. A clean victim is replaced with no write-back.
- R12: busReqValid, busKind and busReqAddr stay stable from the first request cycle until busGrant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request, held until cpuDone |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Processor line address (low bits index the array) |
| cpuDone | output | 1 | One-cycle completion pulse |
| cpuState | output | 2 | Line state after the request, valid with cpuDone |
| busReqValid | output | 1 | Bus transaction request, held until busGrant |
| busKind | output | 2 | 0 read miss, 1 write miss, 2 invalidate |
| busReqAddr | output | ADDR_W | Address of the bus transaction |
| busGrant | input | 1 | Bus has carried the request |
| busSharedIn | input | 1 | Peer caches hold the line, sampled with busGrant |
| wbReq | output | 1 | Write-back of a modified victim, held until wbAck |
| wbAddr | output | ADDR_W | Victim line address |
| wbAck | input | 1 | Write-back accepted |
| snoopValid | input | 1 | A peer transaction is on the bus |
| snoopWrite | input | 1 | 0 read miss, 1 write miss or invalidate |
| snoopAddr | input | ADDR_W | Snooped address |
| snoopShared | output | 1 | This cache holds the snooped line |
| supplyData | output | 1 | This cache offers to source the data |

## Verification
Hits complete with cpuDone exactly one cycle after cpuReq. A miss completes one cycle after the busGrant cycle. Any write-back comes before the bus request and adds its cycles until wbAck. The bench drives inputs on falling edges and samples on falling edges, so it counts edges from the stimulus and compares the count against these figures. Snoop responses are combinational and are sampled shortly after the snoop inputs settle, in the same cycle. The state update that a snoop causes is confirmed afterwards through the processor path, by whether a later access misses, runs silently or issues an invalidate.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    ST_I  = 2'd0,
    ST_VE = 2'd1,
    ST_S  = 2'd2,
    ST_D  = 2'd3
  } cohState_t;

  typedef enum logic [1:0] {
    BUS_RDMISS = 2'd0,
    BUS_WRMISS = 2'd1,
    BUS_INV    = 2'd2
  } busKind_t;

  // strobes from control to the tag/state array
  typedef struct packed {
    logic      latch;     // take the live processor address
    logic      wrLine;    // write the indexed line state
    logic      setTag;    // also overwrite its tag
    cohState_t newState;
  } ctrlStrb_t;
endpackage

// File: rtl/coh_datapath.sv
module coh_datapath
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              snoopValid,
  input  logic              snoopWrite,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic [ADDR_W-1:0] curAddr,
  output logic              lkHit,
  output cohState_t         lineState,
  output logic [ADDR_W-1:0] vicAddr,
  output logic              snoopHit
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  cohState_t        stArr  [LINES];
  logic [TAG_W-1:0] tagArr [LINES];
  logic [ADDR_W-1:0] addrQ;

  logic [IDX_W-1:0] curIdx, sIdx;
  logic [TAG_W-1:0] curTag, sTag;

  assign curAddr   = strb.latch ? cpuAddr : addrQ;
  assign curIdx    = curAddr[IDX_W-1:0];
  assign curTag    = curAddr[ADDR_W-1:IDX_W];
  assign lineState = stArr[curIdx];
  assign lkHit     = (stArr[curIdx] != ST_I) && (tagArr[curIdx] == curTag);
  assign vicAddr   = {tagArr[curIdx], curIdx};

  assign sIdx     = snoopAddr[IDX_W-1:0];
  assign sTag     = snoopAddr[ADDR_W-1:IDX_W];
  assign snoopHit = snoopValid && (stArr[sIdx] != ST_I) && (tagArr[sIdx] == sTag);

  always_ff @(posedge clk) begin
    if (!rstN) addrQ <= '0;
    else if (strb.latch) addrQ <= cpuAddr;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++) begin
      if (!rstN) begin
        stArr[i]  <= ST_I;
        tagArr[i] <= '0;
      end else if (strb.wrLine && curIdx == IDX_W'(i)) begin
        stArr[i] <= strb.newState;
        if (strb.setTag) tagArr[i] <= curTag;
      end else if (snoopHit && sIdx == IDX_W'(i)) begin
        stArr[i] <= snoopWrite ? ST_I : ST_S;
      end
    end
  end

  logic snpFree;
  assign snpFree = !(strb.wrLine && curIdx == sIdx);

  p_snoop_inv_r10: assert property (@(posedge clk) disable iff (!rstN)
    snoopHit && snoopWrite && snpFree |=> stArr[$past(sIdx)] == ST_I);

  p_snoop_demote_r9: assert property (@(posedge clk) disable iff (!rstN)
    snoopHit && !snoopWrite && snpFree |=> stArr[$past(sIdx)] == ST_S);
endmodule

// File: rtl/coh_ctrl.sv
module coh_ctrl
  import coh_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cpuReq,
  input  logic      cpuWrite,
  input  logic      lkHit,
  input  cohState_t lineState,
  input  logic      busGrant,
  input  logic      busSharedIn,
  input  logic      wbAck,
  output ctrlStrb_t strb,
  output logic      cpuDone,
  output cohState_t cpuState,
  output logic      busReqValid,
  output busKind_t  busKind,
  output logic      wbReq
);
  typedef enum logic [1:0] {C_IDLE, C_WB, C_BUS, C_RESP} ctrlSt_t;

  ctrlSt_t   st, stN;
  busKind_t  kindQ, kindN;
  cohState_t respQ, respN;

  always_comb begin
    stN           = st;
    kindN         = kindQ;
    respN         = respQ;
    strb.latch    = (st == C_IDLE);
    strb.wrLine   = 1'b0;
    strb.setTag   = 1'b0;
    strb.newState = ST_I;
    unique case (st)
      C_IDLE: if (cpuReq) begin
        if (lkHit) begin
          if (!cpuWrite) begin
            respN = lineState;
            stN   = C_RESP;
          end else if (lineState == ST_S) begin
            kindN = BUS_INV;
            stN   = C_BUS;
          end else begin
            strb.wrLine   = 1'b1;
            strb.newState = ST_D;
            respN         = ST_D;
            stN           = C_RESP;
          end
        end else begin
          kindN = cpuWrite ? BUS_WRMISS : BUS_RDMISS;
          stN   = (lineState == ST_D) ? C_WB : C_BUS;
        end
      end
      C_WB: if (wbAck) begin
        strb.wrLine   = 1'b1;
        strb.newState = ST_I;
        stN           = C_BUS;
      end
      C_BUS: if (busGrant) begin
        strb.wrLine   = 1'b1;
        strb.setTag   = 1'b1;
        strb.newState = (kindQ != BUS_RDMISS) ? ST_D : (busSharedIn ? ST_S : ST_VE);
        respN         = strb.newState;
        stN           = C_RESP;
      end
      default: stN = C_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st    <= C_IDLE;
      kindQ <= BUS_RDMISS;
      respQ <= ST_I;
    end else begin
      st    <= stN;
      kindQ <= kindN;
      respQ <= respN;
    end
  end

  assign cpuDone     = (st == C_RESP);
  assign cpuState    = respQ;
  assign busReqValid = (st == C_BUS);
  assign busKind     = kindQ;
  assign wbReq       = (st == C_WB);

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |=> !cpuDone);

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    busReqValid && !busGrant |=> busReqValid && $stable(busKind));

  p_ve_write_silent_r5: assert property (@(posedge clk) disable iff (!rstN)
    st == C_IDLE && cpuReq && cpuWrite && lkHit && lineState == ST_VE
    |=> cpuDone && !busReqValid && cpuState == ST_D);

  p_read_hit_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    st == C_IDLE && cpuReq && !cpuWrite && lkHit |=> cpuDone && !busReqValid && !wbReq);
endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              cpuDone,
  output logic [1:0]        cpuState,
  output logic              busReqValid,
  output logic [1:0]        busKind,
  output logic [ADDR_W-1:0] busReqAddr,
  input  logic              busGrant,
  input  logic              busSharedIn,
  output logic              wbReq,
  output logic [ADDR_W-1:0] wbAddr,
  input  logic              wbAck,
  input  logic              snoopValid,
  input  logic              snoopWrite,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              snoopShared,
  output logic              supplyData
);
  ctrlStrb_t         strb;
  logic              lkHit, snoopHit;
  cohState_t         lineState, respState;
  busKind_t          kindE;
  logic [ADDR_W-1:0] curAddr, vicAddr;

  coh_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWrite(cpuWrite),
    .lkHit(lkHit), .lineState(lineState), .busGrant(busGrant),
    .busSharedIn(busSharedIn), .wbAck(wbAck), .strb(strb),
    .cpuDone(cpuDone), .cpuState(respState), .busReqValid(busReqValid),
    .busKind(kindE), .wbReq(wbReq)
  );

  coh_datapath #(.ADDR_W(ADDR_W), .LINES(LINES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cpuAddr(cpuAddr),
    .snoopValid(snoopValid), .snoopWrite(snoopWrite), .snoopAddr(snoopAddr),
    .curAddr(curAddr), .lkHit(lkHit), .lineState(lineState),
    .vicAddr(vicAddr), .snoopHit(snoopHit)
  );

  assign cpuState    = respState;
  assign busKind     = kindE;
  assign busReqAddr  = curAddr;
  assign wbAddr      = vicAddr;
  assign snoopShared = snoopHit;
  assign supplyData  = snoopHit && !snoopWrite;

  p_addr_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    busReqValid && !busGrant |=> $stable(busReqAddr));

  p_wb_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    wbReq && !wbAck |=> wbReq && $stable(wbAddr) && !busReqValid);

  p_supply_match_r8: assert property (@(posedge clk) disable iff (!rstN)
    supplyData |-> snoopShared && snoopValid);
endmodule

// File: tb/snoop_coh_ctrl_tb.sv
module snoop_coh_ctrl_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReq = 1'b0, cpuWrite = 1'b0;
  logic [7:0] cpuAddr = '0;
  logic cpuDone;
  logic [1:0] cpuState;
  logic busReqValid;
  logic [1:0] busKind;
  logic [7:0] busReqAddr;
  logic busGrant = 1'b0, busSharedIn = 1'b0;
  logic wbReq;
  logic [7:0] wbAddr;
  logic wbAck = 1'b0;
  logic snoopValid = 1'b0, snoopWrite = 1'b0;
  logic [7:0] snoopAddr = '0;
  logic snoopShared, supplyData;

  int nChecks = 0;
  int nErr = 0;

  always #4 clk = ~clk;

  snoop_coh_ctrl #(.ADDR_W(8), .LINES(4)) u_dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // result of one processor access
  int busCnt, wbCycles, lat, addrMoves;
  logic [1:0] kindSeen, stSeen;
  logic [7:0] rqSeen, wbSeen;

  task automatic access(input logic wr, input logic [7:0] a, input logic sh);
    int waitB = 0;
    int waitW = 0;
    logic done = 1'b0;
    busCnt = 0; wbCycles = 0; lat = 0; addrMoves = 0;
    kindSeen = 2'd3; stSeen = 2'd0; rqSeen = '0; wbSeen = '0;
    @(negedge clk);
    cpuReq = 1'b1; cpuWrite = wr; cpuAddr = a; busSharedIn = sh;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
      busGrant = 1'b0;
      wbAck = 1'b0;
      if (cpuDone) begin
        stSeen = cpuState;
        done = 1'b1;
        cpuReq = 1'b0;
      end else if (busReqValid) begin
        if (waitB == 0) begin
          busCnt++;
          kindSeen = busKind;
          rqSeen = busReqAddr;
          waitB = 1;
        end else begin
          if (busReqAddr != rqSeen || busKind != kindSeen) addrMoves++;
          busGrant = 1'b1;
          waitB = 0;
        end
      end else if (wbReq) begin
        if (wbCycles == 0) wbSeen = wbAddr;
        wbCycles++;
        waitW++;
        if (waitW >= 2) wbAck = 1'b1;
      end
    end
    busSharedIn = 1'b0;
  endtask

  task automatic snoop(input logic wr, input logic [7:0] a,
                       output logic sh, output logic sup);
    @(negedge clk);
    snoopValid = 1'b1; snoopWrite = wr; snoopAddr = a;
    #1;
    sh = snoopShared;
    sup = supplyData;
    @(negedge clk);
    snoopValid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 busReqValid after reset", busReqValid, 0);
    chk("R1 wbReq after reset", wbReq, 0);
    chk("R1 cpuDone after reset", cpuDone, 0);
    access(1'b0, 8'h10, 1'b0);
    chk("R1 first read misses", busCnt, 1);
    chk("R7 read miss kind", kindSeen, 0);
    chk("R12 request address", rqSeen, 8'h10);
    chk("R12 request held until grant", addrMoves, 0);
    chk("R2 fill from memory", stSeen, 1);
    chk("R2 done one cycle after grant", lat, 3);
  endtask

  task automatic t_hits;
    access(1'b0, 8'h10, 1'b0);
    chk("R4 read hit on exclusive no bus", busCnt, 0);
    chk("R4 read hit keeps state", stSeen, 1);
    chk("R4 read hit latency", lat, 1);
    access(1'b1, 8'h10, 1'b0);
    chk("R5 silent upgrade no bus", busCnt, 0);
    chk("R5 upgrade to modified", stSeen, 3);
    chk("R5 upgrade latency", lat, 1);
    access(1'b0, 8'h10, 1'b0);
    chk("R4 read hit on modified", stSeen, 3);
    chk("R4 read hit on modified no bus", busCnt, 0);
  endtask

  task automatic t_snoopRead;
    logic sh, sup;
    snoop(1'b0, 8'h10, sh, sup);
    chk("R8 snoop read shared on modified", sh, 1);
    chk("R8 snoop read supply on modified", sup, 1);
    access(1'b0, 8'h10, 1'b0);
    chk("R9 modified demoted to shared", stSeen, 2);
    chk("R4 read hit on shared no bus", busCnt, 0);
    access(1'b1, 8'h10, 1'b0);
    chk("R6 shared write issues request", busCnt, 1);
    chk("R6 invalidate kind", kindSeen, 2);
    chk("R6 ends modified", stSeen, 3);
  endtask

  task automatic t_snoopWrite;
    logic sh, sup;
    snoop(1'b1, 8'h10, sh, sup);
    chk("R8 snoop write shared sense", sh, 1);
    chk("R8 snoop write no supply", sup, 0);
    access(1'b0, 8'h10, 1'b0);
    chk("R10 invalidated line misses", busCnt, 1);
    chk("R10 no write-back of invalid line", wbCycles, 0);
    snoop(1'b0, 8'h10, sh, sup);
    chk("R9 exclusive snooped read", sh, 1);
    access(1'b0, 8'h10, 1'b0);
    chk("R9 exclusive demoted to shared", stSeen, 2);
  endtask

  task automatic t_sharedFill;
    logic sh, sup;
    access(1'b0, 8'h21, 1'b1);
    chk("R3 fill shared when peers hold", stSeen, 2);
    snoop(1'b0, 8'h21, sh, sup);
    chk("R8 clean shared line supplies", sup, 1);
    snoop(1'b0, 8'h25, sh, sup);
    chk("R8 tag mismatch no shared", sh, 0);
    chk("R8 tag mismatch no supply", sup, 0);
    access(1'b0, 8'h61, 1'b0);
    chk("R11 clean victim no write-back", wbCycles, 0);
    chk("R11 clean victim read miss", busCnt, 1);
  endtask

  task automatic t_evict;
    access(1'b1, 8'h42, 1'b0);
    chk("R7 write miss kind", kindSeen, 1);
    chk("R7 write miss fills modified", stSeen, 3);
    access(1'b0, 8'h82, 1'b0);
    chk("R11 write-back address", wbSeen, 8'h42);
    chk("R11 write-back held until ack", wbCycles, 2);
    chk("R11 bus request after write-back", busCnt, 1);
    chk("R11 refill address", rqSeen, 8'h82);
    chk("R2 refill exclusive", stSeen, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset;
    t_hits;
    t_snoopRead;
    t_snoopWrite;
    t_sharedFill;
    t_evict;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    nErr++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule